// File: doc/BRIEF.md
# Special Bus Cycle Generator

This block converts one-clock event pulses from the processor core into encoded special bus cycles on a host bus with a 64-bit data path and eight active-low byte enables. Each event has a fixed byte-enable pattern and a fixed value on address bits 31:3. The cycle-type lines mark the transfer as a special cycle. Each transfer opens with a one-clock address strobe and is held until the system answers with an active-low ready.

The events are shutdown, cache invalidate, stop grant, halt, writeback-and-invalidate, flush acknowledge and branch trace. A branch-trace cycle has two transfers. The first carries the instruction pointer of the branch on data bits 31:0 and the second carries the pointer of the branch target. The byte-enable pattern for branch trace marks the low lanes as disabled, but the pointers on those lanes are still valid. Branch trace is gated by an 8-bit hardware configuration input.

Requests are collected in a pending register. One cycle runs at a time. When several events are waiting, a fixed priority picks the next one.

Top module: `spcyc_gen`

## Requirements
- R1: After reset and whenever no special cycle is active, `be_n` is 8'hFF, `ads_n` is 1, `dc`, `mio` and `wr` are 0, `adr` is 0 and `dout` is 0.
- R2: Shutdown drives `be_n`=8'hFE, cache invalidate 8'hFD, writeback-and-invalidate 8'hF7 and flush acknowledge 8'hEF. Each of these drives `adr` (address bits 31:3) to 0 and `dout` to 0.
- R3: Halt and stop grant both drive `be_n`=8'hFB. Halt drives byte address 0. Stop grant drives byte address 0x10, so only A4 is high and `adr` equals 2.
- R4: Branch trace drives `be_n`=8'hDF and `adr`=0 over two transfers. `dout[31:0]` holds the source pointer in the first transfer and the target pointer in the second. `dout[63:32]` is 0 in both transfers.
- R5: While a special cycle is active, `dc`=0, `mio`=0 and `wr`=1.
- R6: `ads_n` is low for exactly one clock per transfer. `be_n`, `adr` and `dout` stay unchanged until `rdy_n` is sampled low.
- R7: A branch-trace request is accepted only when `cfg[5]`=1 and `cfg[3:1]`=3'b001 in the clock of the request. Otherwise the request is dropped and no cycle is started.
- R8: When several requests are pending, they are served in this order: shutdown, flush acknowledge, writeback-and-invalidate, invalidate, stop grant, halt, branch trace.
- R9: A request that arrives during a cycle does not interrupt that cycle. It is served after the cycle ends. Repeated requests for an event that is still pending produce a single cycle.
- R10: A branch-trace request that arrives while a branch trace is pending or running is dropped. The first request's pointers are kept.
- R11: `rdy_n` is not sampled in the clock where `ads_n` is low. A transfer always lasts at least two clocks, even when `rdy_n` is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_shut | input | 1 | Shutdown request pulse |
| ev_inv | input | 1 | Cache invalidate request pulse |
| ev_stpg | input | 1 | Stop grant request pulse |
| ev_halt | input | 1 | Halt request pulse |
| ev_wbinv | input | 1 | Writeback-and-invalidate request pulse |
| ev_flush | input | 1 | Flush acknowledge request pulse |
| ev_trace | input | 1 | Branch-trace request pulse |
| trace_src | input | 32 | Branch instruction pointer, taken with ev_trace |
| trace_dst | input | 32 | Branch target pointer, taken with ev_trace |
| cfg | input | 8 | Hardware configuration, gates branch trace |
| rdy_n | input | 1 | Active-low ready from the system |
| ads_n | output | 1 | Active-low address strobe, one clock per transfer |
| be_n | output | 8 | Active-low byte enables |
| adr | output | 29 | Address bits 31:3 |
| dout | output | 64 | Data bus |
| dc | output | 1 | Data/code line |
| mio | output | 1 | Memory/IO line |
| wr | output | 1 | Write/read line |

## Verification
Two things can happen in the same clock: a new request landing in the pending register, and the sequencer granting or finishing a cycle. The bench provokes this overlap in three ways. It pulses all seven requests together. It pulses requests while a slow responder keeps a cycle open. It pulses a second branch trace while the first trace's transfers are still running. A scoreboard queue holds the expected byte enables, address and data of each transfer, in priority order. Any extra, missing or reordered address strobe is reported as a mismatch.

// File: rtl/spcyc_pkg.sv
package spcyc_pkg;
  localparam int NUM_EV = 7;
  localparam int ADR_W  = 29;
  localparam int BE_W   = 8;

  // index order is the service priority, 0 first
  typedef enum logic [2:0] {
    EV_SHUT  = 3'd0,
    EV_FLUSH = 3'd1,
    EV_WBINV = 3'd2,
    EV_INV   = 3'd3,
    EV_STPG  = 3'd4,
    EV_HALT  = 3'd5,
    EV_TRACE = 3'd6
  } ev_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ADS, ST_WAIT} st_e;

  function automatic logic [BE_W-1:0] ev_be(ev_e e);
    case (e)
      EV_SHUT:  return 8'hFE;
      EV_INV:   return 8'hFD;
      EV_STPG:  return 8'hFB;
      EV_HALT:  return 8'hFB;
      EV_WBINV: return 8'hF7;
      EV_FLUSH: return 8'hEF;
      EV_TRACE: return 8'hDF;
      default:  return 8'hFF;
    endcase
  endfunction

  // address bits 31:3; stop grant sits at byte address 0x10
  function automatic logic [ADR_W-1:0] ev_adr(ev_e e);
    return (e == EV_STPG) ? ADR_W'(2) : '0;
  endfunction

  function automatic logic trace_cfg_ok(logic [7:0] c);
    return c[5] && (c[3:1] == 3'b001);
  endfunction
endpackage

// File: rtl/spcyc_reqlatch.sv
module spcyc_reqlatch
  import spcyc_pkg::*;
#(
  parameter int N    = NUM_EV,
  parameter int IP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [7:0]      cfg,
  input  logic [IP_W-1:0] src_in,
  input  logic [IP_W-1:0] dst_in,
  input  logic [N-1:0]    clr,
  input  logic            trace_busy,
  output logic [N-1:0]    pend,
  output logic [IP_W-1:0] src_q,
  output logic [IP_W-1:0] dst_q
);
  localparam int TR = N - 1;

  logic         trace_take;
  logic [N-1:0] acc;

  assign trace_take = req[TR] && trace_cfg_ok(cfg) && !pend[TR] && !trace_busy;

  always_comb begin
    acc     = req;
    acc[TR] = trace_take;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      pend <= (pend & ~clr) | acc;
      if (trace_take) begin
        src_q <= src_in;
        dst_q <= dst_in;
      end
    end
  end

  // R7
  trace_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req[TR] && !trace_cfg_ok(cfg) && !pend[TR]) |=> !pend[TR]);
endmodule

// File: rtl/spcyc_arb.sv
module spcyc_arb #(
  parameter int N     = 7,
  localparam int IX_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [N-1:0]    pend,
  output logic [N-1:0]    grant,
  output logic [IX_W-1:0] idx,
  output logic            any
);
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant[i] = en & pend[i];
    end else begin : g_rest
      assign grant[i] = en & pend[i] & ~|pend[i-1:0];
    end
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (grant[i]) idx = IX_W'(i);
  end

  assign any = |grant;

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/spcyc_fsm.sv
module spcyc_fsm
  import spcyc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic grant_any,
  input  ev_e  grant_ev,
  input  logic rdy_n,
  output st_e  st,
  output ev_e  cur_ev,
  output logic phase,
  output logic busy,
  output logic ads
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cur_ev <= EV_SHUT;
      phase  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (grant_any) begin
          cur_ev <= grant_ev;
          phase  <= 1'b0;
          st     <= ST_ADS;
        end
        ST_ADS: st <= ST_WAIT;
        ST_WAIT: if (!rdy_n) begin
          if (cur_ev == EV_TRACE && !phase) begin
            phase <= 1'b1;
            st    <= ST_ADS;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);
  assign ads  = (st == ST_ADS);

  // R6
  ads_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ads |=> !ads);
  // R9
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && rdy_n) |=> (cur_ev == $past(cur_ev)));
endmodule

// File: rtl/spcyc_gen.sv
module spcyc_gen
  import spcyc_pkg::*;
#(
  parameter int IP_W   = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_shut,
  input  logic              ev_inv,
  input  logic              ev_stpg,
  input  logic              ev_halt,
  input  logic              ev_wbinv,
  input  logic              ev_flush,
  input  logic              ev_trace,
  input  logic [IP_W-1:0]   trace_src,
  input  logic [IP_W-1:0]   trace_dst,
  input  logic [7:0]        cfg,
  input  logic              rdy_n,
  output logic              ads_n,
  output logic [BE_W-1:0]   be_n,
  output logic [ADR_W-1:0]  adr,
  output logic [DATA_W-1:0] dout,
  output logic              dc,
  output logic              mio,
  output logic              wr
);
  localparam int IX_W = $clog2(NUM_EV);

  logic [NUM_EV-1:0] req_vec, pend, grant;
  logic [IX_W-1:0]   gidx;
  logic              gany, busy, ads, phase, trace_busy;
  logic [IP_W-1:0]   src_q, dst_q, ip_sel;
  st_e               st;
  ev_e               cur_ev;

  // packed in priority order
  assign req_vec = {ev_trace, ev_halt, ev_stpg, ev_inv, ev_wbinv, ev_flush, ev_shut};

  spcyc_reqlatch #(.N(NUM_EV), .IP_W(IP_W)) i_latch (
    .clk, .rst_n, .req(req_vec), .cfg, .src_in(trace_src), .dst_in(trace_dst),
    .clr(grant), .trace_busy, .pend, .src_q, .dst_q);

  spcyc_arb #(.N(NUM_EV)) i_arb (
    .clk, .rst_n, .en(st == ST_IDLE), .pend, .grant, .idx(gidx), .any(gany));

  spcyc_fsm i_fsm (
    .clk, .rst_n, .grant_any(gany), .grant_ev(ev_e'(gidx)), .rdy_n,
    .st, .cur_ev, .phase, .busy, .ads);

  assign trace_busy = busy && (cur_ev == EV_TRACE);
  assign ip_sel     = phase ? dst_q : src_q;

  assign ads_n = ~ads;
  assign be_n  = busy ? ev_be(cur_ev) : '1;
  assign adr   = busy ? ev_adr(cur_ev) : '0;
  assign dout  = trace_busy ? {{(DATA_W-IP_W){1'b0}}, ip_sel} : '0;
  assign dc    = 1'b0;
  assign mio   = 1'b0;
  assign wr    = busy;

  // R5
  ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |-> (wr && !dc && !mio));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && rdy_n) |=> ($stable(be_n) && $stable(adr) && $stable(dout)));
endmodule

// File: tb/test_spcyc_gen.sv
module test_spcyc_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [6:0]  rq;   // shut, inv, stpg, halt, wbinv, flush, trace
  logic [31:0] tsrc, tdst;
  logic [7:0]  cfg;
  logic        rdy_n;
  logic        ads_n, dc, mio, wr;
  logic [7:0]  be_n;
  logic [28:0] adr;
  logic [63:0] dout;

  spcyc_gen i_spcyc_gen (
    .clk, .rst_n, .ev_shut(rq[0]), .ev_inv(rq[1]), .ev_stpg(rq[2]),
    .ev_halt(rq[3]), .ev_wbinv(rq[4]), .ev_flush(rq[5]), .ev_trace(rq[6]),
    .trace_src(tsrc), .trace_dst(tdst), .cfg, .rdy_n,
    .ads_n, .be_n, .adr, .dout, .dc, .mio, .wr);

  typedef struct packed {
    logic [7:0]  be;
    logic [28:0] adr;
    logic [63:0] d;
  } xp_t;

  xp_t   q[$];
  int    total = 0, bad = 0, ads_cnt = 0, cyc = 0;
  int    dly = 2, wcnt = 0;
  logic  tie = 1'b0;
  xp_t   cap;

  task automatic chk(input logic ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // bench-side encoding table (bit index of rq)
  task automatic expect_ev(input int e, input logic [31:0] s, input logic [31:0] d);
    case (e)
      0: q.push_back('{8'hFE, 29'd0, 64'd0});
      1: q.push_back('{8'hFD, 29'd0, 64'd0});
      2: q.push_back('{8'hFB, 29'd2, 64'd0});
      3: q.push_back('{8'hFB, 29'd0, 64'd0});
      4: q.push_back('{8'hF7, 29'd0, 64'd0});
      5: q.push_back('{8'hEF, 29'd0, 64'd0});
      default: begin
        q.push_back('{8'hDF, 29'd0, {32'd0, s}});
        q.push_back('{8'hDF, 29'd0, {32'd0, d}});
      end
    endcase
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); rq = v;
    @(negedge clk); rq = '0;
  endtask

  task automatic settle(input string r);
    int n = 0;
    while ((q.size() != 0 || wr || !ads_n) && n < 400) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    chk(q.size() == 0 && !wr, r, q.size(), 0);
  endtask

  task automatic idle_chk(input string r);
    chk(be_n == 8'hFF && ads_n && !dc && !mio && !wr && adr == 0 && dout == 0, r,
        {be_n, ads_n, dc, mio, wr}, {8'hFF, 4'b1000});
  endtask

  // monitor: pops the scoreboard on every address strobe
  always @(negedge clk) begin
    if (rst_n && !ads_n) begin
      ads_cnt++;
      if (q.size() == 0) begin
        chk(1'b0, "R9 unexpected cycle", {be_n, adr}, 0);
      end else begin
        xp_t e;
        e = q.pop_front();
        chk(be_n == e.be && adr == e.adr, "R2/R3/R4 code", {be_n, adr}, {e.be, e.adr});
        chk(dout == e.d, "R4 data", dout, e.d);
        chk(!dc && !mio && wr, "R5 ctl", {dc, mio, wr}, 3'b001);
      end
    end
  end

  // responder
  always @(negedge clk) begin
    if (tie) begin
      rdy_n = 1'b0;
    end else begin
      rdy_n = 1'b1;
      if (rst_n && !ads_n) begin
        cap  = '{be_n, adr, dout};
        wcnt = dly;
      end else if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) begin
          chk(be_n == cap.be && adr == cap.adr && dout == cap.d && wr, "R6 hold",
              {be_n, adr, dout}, {cap.be, cap.adr, cap.d});
          rdy_n = 1'b0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; rq = '0; tsrc = '0; tdst = '0; cfg = 8'h22; rdy_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_chk("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // single events: R2, R3
    for (int e = 0; e < 6; e++) begin
      expect_ev(e, 0, 0);
      pulse(7'(1 << e));
      settle("R2/R3 single");
      idle_chk("R1 after cycle");
    end

    // branch trace: R4
    tsrc = 32'h1234_5678; tdst = 32'h9ABC_DEF0;
    n = ads_cnt;
    expect_ev(6, tsrc, tdst);
    pulse(7'h40);
    settle("R4 trace");
    chk(ads_cnt == n + 2, "R4 two transfers", ads_cnt - n, 2);

    // gating: R7
    cfg = 8'h02; n = ads_cnt;
    pulse(7'h40); settle("R7 bit5 low");
    chk(ads_cnt == n, "R7 dropped bit5", ads_cnt - n, 0);
    cfg = 8'h24; n = ads_cnt;
    pulse(7'h40); settle("R7 field");
    chk(ads_cnt == n, "R7 dropped field", ads_cnt - n, 0);
    cfg = 8'h23; tsrc = 32'hCAFE_0001; tdst = 32'hCAFE_0002;
    expect_ev(6, tsrc, tdst);
    pulse(7'h40); settle("R7 enabled bit0 set");
    cfg = 8'h22;

    // priority: R8
    tsrc = 32'h0000_AAAA; tdst = 32'h0000_BBBB;
    expect_ev(0, 0, 0); expect_ev(5, 0, 0); expect_ev(4, 0, 0); expect_ev(1, 0, 0);
    expect_ev(2, 0, 0); expect_ev(3, 0, 0); expect_ev(6, tsrc, tdst);
    pulse(7'h7F);
    settle("R8 order");

    // no preemption and merging: R9
    dly = 6;
    expect_ev(3, 0, 0); expect_ev(0, 0, 0);
    pulse(7'h08); repeat (2) @(negedge clk); pulse(7'h01);
    settle("R9 no preempt");
    expect_ev(3, 0, 0); expect_ev(1, 0, 0);
    pulse(7'h08); pulse(7'h02); pulse(7'h02);
    settle("R9 merge");

    // second trace while first runs: R10
    tsrc = 32'h1111_0000; tdst = 32'h2222_0000; n = ads_cnt;
    expect_ev(6, tsrc, tdst);
    pulse(7'h40);
    tsrc = 32'h3333_0000; tdst = 32'h4444_0000;
    @(negedge clk); pulse(7'h40);
    settle("R10 drop");
    chk(ads_cnt == n + 2, "R10 strobes", ads_cnt - n, 2);
    dly = 2;

    // ready held low through the strobe clock: R11
    tie = 1'b1;
    expect_ev(3, 0, 0);
    pulse(7'h08);
    @(negedge clk);
    chk(!ads_n, "R11 strobe", ads_n, 0);
    @(negedge clk);
    chk(ads_n && wr, "R11 still active", {ads_n, wr}, 2'b11);
    @(negedge clk);
    chk(!wr, "R11 ends", wr, 0);
    tie = 1'b0;
    settle("R11 settle");
    idle_chk("R1 final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule